// File: doc/BRIEF.md
# Framed Serial Write Receiver

This block accepts write transfers from an external microcontroller over three wires: a frame strobe, a serial data line and a serial clock. The serial clock is not related to the local system clock. All three lines are synchronised into the system clock domain, and their edges are detected there. The system clock must run at least four times faster than the serial clock. A frame opens on a rising strobe. Its first byte is a control byte that selects a target and, for a FIFO target, declares how many bytes are to be sent to the host. Every later byte is either appended to one of four small transmit FIFOs or written into one of four internal registers.

When the strobe falls on a frame that was aimed at a FIFO, the block latches the declared length and the toggle flag for that FIFO. It also clears the FIFO's transfer-done bit, which tells the host-side engine that a packet is ready. The host-side engine sets that bit again through a pulse input. It reads the stored bytes through a peek port whose index counts from the oldest byte held.

Top module: `serial_write_rx`

## Requirements
- R1: After reset every FIFO fill count, declared length, toggle flag and register reads zero, and every transfer-done bit reads one.
- R2: Bits are taken from the data line on rising edges of the serial clock, least significant bit first. The first byte of a frame is the control byte, and the data bytes that follow are stored in arrival order, so peek index 0 returns the oldest stored byte.
- R3: Control byte fields: bits 7..5 hold the target (0 to 3 selects FIFO 0 to 3, 4 to 7 selects register 0 to 3), bit 4 holds the toggle flag, and bits 3..0 hold the declared length.
- R4: A control byte aimed at a FIFO empties that FIFO. Each complete data byte written to it then adds one to its fill count.
- R5: Once a FIFO holds 8 bytes, each further byte overwrites the oldest. The fill count stays at 8, and the newest 8 bytes remain readable in order.
- R6: When the strobe falls on a committing FIFO frame, that FIFO's transfer-done bit clears, and its declared length and toggle flag take the values from the control byte.
- R7: For a register target, each complete data byte is written into the register, so the last byte wins. The length and toggle bits are ignored, and no fill count or transfer-done bit changes.
- R8: A FIFO frame with a declared length of zero commits only if at least one extra serial clock followed the control byte. Without that extra clock, the transfer-done bit and the declared length keep their values.
- R9: A byte cut short by the end of the frame is discarded. A frame that ends before its control byte is complete changes nothing.
- R10: Serial clock edges while the strobe is low have no effect on any fill count, stored byte or register.
- R11: A pulse on bit k of done_set_i sets transfer-done bit k. A commit to the same FIFO in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the microcontroller (asynchronous) |
| strobe_i | input | 1 | Frame strobe, high for the duration of a frame |
| sdata_i | input | 1 | Serial data, changed on falling serial clock |
| done_set_i | input | 4 | Per-FIFO pulse that sets the transfer-done bit |
| rd_sel_i | input | 2 | FIFO selected for the peek port |
| rd_idx_i | input | 3 | Peek index counted from the oldest byte |
| fill_o | output | 16 | Fill count per FIFO, 4 bits each, FIFO 0 in the low bits |
| txlen_o | output | 16 | Declared length per FIFO, 4 bits each |
| tog_o | output | 4 | Toggle flag per FIFO |
| done_o | output | 4 | Transfer-done bit per FIFO |
| reg_o | output | 32 | Four 8-bit registers, register 0 in the low byte |
| rd_data_o | output | 8 | Byte at the peek position |

## Verification
The hardest condition to reach from the ports is a FIFO that has wrapped. The write pointer and the oldest-byte position must then differ, and the peek port must return bytes across the wrap. The stimulus reaches this with a frame of eleven data bytes into one FIFO, then reads all eight positions. The zero-length frame with and without its extra clock, the frame cut off inside the control byte, and serial clock activity outside a frame each get their own directed frame. Each case is checked against state that was observed before the stimulus.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int BYTE_W = 8;
  localparam int TGT_W  = 3;
  localparam int LEN_W  = 4;

  typedef struct packed {
    logic [TGT_W-1:0] tgt;
    logic             tog;
    logic [LEN_W-1:0] len;
  } ctl_t;

  // position in a ring of 'depth' entries of the idx-th oldest byte
  function automatic int ring_pos(int wptr, int fill, int idx, int depth);
    return (wptr - fill + idx + 2 * depth) % depth;
  endfunction

  function automatic int fill_next(int fill, int depth);
    return (fill < depth) ? fill + 1 : depth;
  endfunction

  function automatic logic tgt_is_fifo(int tgt, int nfifo);
    return tgt < nfifo;
  endfunction

  function automatic logic tgt_is_reg(int tgt, int nfifo, int nreg);
    return (tgt >= nfifo) && (tgt < nfifo + nreg);
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
      prev_o <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
      prev_o <= q_o;
    end
  end
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sck_p,
  input  logic              sin_s,
  input  logic              sin_p,
  input  logic              sdi_s,
  output logic              in_frame_o,
  output logic              ctrl_ev_o,
  output logic              data_ev_o,
  output logic              frame_end_ev_o,
  output logic [BYTE_W-1:0] byte_o,
  output ctl_t              ctl_o,
  output logic              have_ctl_o,
  output logic              extra_o
);
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              sck_rise, sin_rise, sin_fall, bit_ev, byte_ev;

  assign sck_rise = sck_s & ~sck_p;
  assign sin_rise = sin_s & ~sin_p;
  assign sin_fall = ~sin_s & sin_p;
  assign bit_ev   = in_frame_o & sck_rise;
  assign byte_ev  = bit_ev & (bitcnt == 3'd7);
  assign byte_o   = {sdi_s, shreg[BYTE_W-1:1]};

  assign ctrl_ev_o      = byte_ev & ~have_ctl_o;
  assign data_ev_o      = byte_ev & have_ctl_o;
  assign frame_end_ev_o = in_frame_o & sin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_o <= 1'b0;
      have_ctl_o <= 1'b0;
      extra_o    <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      ctl_o      <= '0;
    end else if (sin_rise) begin
      in_frame_o <= 1'b1;
      have_ctl_o <= 1'b0;
      extra_o    <= 1'b0;
      bitcnt     <= '0;
    end else if (sin_fall) begin
      in_frame_o <= 1'b0;
    end else if (bit_ev) begin
      shreg  <= byte_o;
      bitcnt <= bitcnt + 3'd1;
      if (have_ctl_o) extra_o <= 1'b1;
      if (ctrl_ev_o) begin
        have_ctl_o <= 1'b1;
        ctl_o      <= ctl_t'(byte_o);
      end
    end
  end
endmodule

// File: rtl/srx_store.sv
module srx_store
  import srx_pkg::*;
#(
  parameter int NFIFO = 4,
  parameter int NREG  = 4,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH),
  localparam int SW   = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_ev_i,
  input  logic                  data_ev_i,
  input  logic                  frame_end_ev_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  ctl_t                  ctl_i,
  input  logic                  have_ctl_i,
  input  logic                  extra_i,
  input  logic [NFIFO-1:0]      done_set_i,
  input  logic [SW-1:0]         rd_sel_i,
  input  logic [PW-1:0]         rd_idx_i,
  output logic [NFIFO*CW-1:0]   fill_o,
  output logic [NFIFO*LEN_W-1:0] txlen_o,
  output logic [NFIFO-1:0]      tog_o,
  output logic [NFIFO-1:0]      done_o,
  output logic [NREG*BYTE_W-1:0] reg_o,
  output logic [BYTE_W-1:0]     rd_data_o,
  output logic                  commit_ev_o,
  output logic [SW-1:0]         commit_sel_o,
  output logic                  wr_ev_o,
  output logic [SW-1:0]         wr_sel_o
);
  ctl_t new_ctl;
  logic cur_fifo, cur_reg, new_fifo, reg_wr;
  logic [BYTE_W-1:0] peek [NFIFO];

  assign new_ctl  = ctl_t'(byte_i);
  assign cur_fifo = tgt_is_fifo(int'(ctl_i.tgt), NFIFO);
  assign cur_reg  = tgt_is_reg(int'(ctl_i.tgt), NFIFO, NREG);
  assign new_fifo = ctrl_ev_i & tgt_is_fifo(int'(new_ctl.tgt), NFIFO);
  assign reg_wr   = data_ev_i & cur_reg;

  assign wr_ev_o      = data_ev_i & cur_fifo;
  assign wr_sel_o     = SW'(ctl_i.tgt);
  assign commit_ev_o  = frame_end_ev_i & have_ctl_i & cur_fifo &
                        ((ctl_i.len != '0) | extra_i);
  assign commit_sel_o = SW'(ctl_i.tgt);

  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr;
    logic [CW-1:0]     fill;
    logic [LEN_W-1:0]  len_q;
    logic              tog_q, done_q;
    logic              hit_new, hit_wr, hit_cm;

    assign hit_new = new_fifo & (int'(new_ctl.tgt) == f);
    assign hit_wr  = wr_ev_o & (int'(ctl_i.tgt) == f);
    assign hit_cm  = commit_ev_o & (int'(ctl_i.tgt) == f);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wptr <= '0;
        fill <= '0;
      end else if (hit_new) begin
        wptr <= '0;
        fill <= '0;
      end else if (hit_wr) begin
        wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + PW'(1);
        fill <= CW'(fill_next(int'(fill), DEPTH));
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) mem[wptr] <= byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q <= 1'b1;
        len_q  <= '0;
        tog_q  <= 1'b0;
      end else if (hit_cm) begin
        done_q <= 1'b0;
        len_q  <= ctl_i.len;
        tog_q  <= ctl_i.tog;
      end else if (done_set_i[f]) begin
        done_q <= 1'b1;
      end
    end

    assign fill_o[f*CW +: CW]       = fill;
    assign txlen_o[f*LEN_W +: LEN_W] = len_q;
    assign tog_o[f]                 = tog_q;
    assign done_o[f]                = done_q;
    assign peek[f] = mem[PW'(ring_pos(int'(wptr), int'(fill), int'(rd_idx_i), DEPTH))];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [BYTE_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else if (reg_wr && (int'(ctl_i.tgt) - NFIFO == r)) val <= byte_i;
    end
    assign reg_o[r*BYTE_W +: BYTE_W] = val;
  end

  assign rd_data_o = peek[rd_sel_i];
endmodule

// File: rtl/serial_write_rx.sv
module serial_write_rx
  import srx_pkg::*;
#(
  parameter int NFIFO = 4,
  parameter int NREG  = 4,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH),
  localparam int SW   = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck_i,
  input  logic                   strobe_i,
  input  logic                   sdata_i,
  input  logic [NFIFO-1:0]       done_set_i,
  input  logic [SW-1:0]          rd_sel_i,
  input  logic [PW-1:0]          rd_idx_i,
  output logic [NFIFO*CW-1:0]    fill_o,
  output logic [NFIFO*LEN_W-1:0] txlen_o,
  output logic [NFIFO-1:0]       tog_o,
  output logic [NFIFO-1:0]       done_o,
  output logic [NREG*BYTE_W-1:0] reg_o,
  output logic [BYTE_W-1:0]      rd_data_o
);
  logic [2:0] line_s, line_p;
  logic       in_frame, ctrl_ev, data_ev, frame_end_ev, have_ctl, extra;
  logic [BYTE_W-1:0] byte_w;
  ctl_t       ctl_q;
  logic       commit_ev, wr_ev;
  logic [SW-1:0] commit_sel, wr_sel;

  srx_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sdata_i, strobe_i, sck_i}),
    .q_o(line_s), .prev_o(line_p)
  );

  srx_deser u_deser (
    .clk(clk), .rst_n(rst_n),
    .sck_s(line_s[0]), .sck_p(line_p[0]),
    .sin_s(line_s[1]), .sin_p(line_p[1]),
    .sdi_s(line_s[2]),
    .in_frame_o(in_frame), .ctrl_ev_o(ctrl_ev), .data_ev_o(data_ev),
    .frame_end_ev_o(frame_end_ev), .byte_o(byte_w), .ctl_o(ctl_q),
    .have_ctl_o(have_ctl), .extra_o(extra)
  );

  srx_store #(.NFIFO(NFIFO), .NREG(NREG), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ctrl_ev_i(ctrl_ev), .data_ev_i(data_ev), .frame_end_ev_i(frame_end_ev),
    .byte_i(byte_w), .ctl_i(ctl_q), .have_ctl_i(have_ctl), .extra_i(extra),
    .done_set_i(done_set_i), .rd_sel_i(rd_sel_i), .rd_idx_i(rd_idx_i),
    .fill_o(fill_o), .txlen_o(txlen_o), .tog_o(tog_o), .done_o(done_o),
    .reg_o(reg_o), .rd_data_o(rd_data_o),
    .commit_ev_o(commit_ev), .commit_sel_o(commit_sel),
    .wr_ev_o(wr_ev), .wr_sel_o(wr_sel)
  );
endmodule

// File: rtl/serial_write_rx_chk.sv
module serial_write_rx_chk #(
  parameter int NFIFO = 4,
  parameter int NREG  = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int SW    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_frame,
  input logic                 commit_ev,
  input logic [SW-1:0]        commit_sel,
  input logic                 wr_ev,
  input logic [SW-1:0]        wr_sel,
  input logic [NFIFO-1:0]     done_set_i,
  input logic [NFIFO*CW-1:0]  fill_o,
  input logic [NFIFO-1:0]     done_o,
  input logic [NREG*8-1:0]    reg_o
);
  function automatic int fill_at(logic [NFIFO*CW-1:0] v, logic [SW-1:0] i);
    return int'(v[int'(i)*CW +: CW]);
  endfunction

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && fill_at(fill_o, wr_sel) < DEPTH)
    |=> fill_at(fill_o, $past(wr_sel)) == fill_at($past(fill_o), $past(wr_sel)) + 1);

  // R5
  fill_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && fill_at(fill_o, wr_sel) == DEPTH)
    |=> fill_at(fill_o, $past(wr_sel)) == DEPTH);

  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> !done_o[$past(commit_sel)]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> ($stable(fill_o) && $stable(reg_o)));

  // R11
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|done_set_i) && !commit_ev)
    |=> ((done_o & $past(done_set_i)) == $past(done_set_i)));

  for (genvar f = 0; f < NFIFO; f++) begin : g_bound
    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_o[f*CW +: CW]) <= DEPTH);
  end
endmodule

bind serial_write_rx serial_write_rx_chk #(
  .NFIFO(NFIFO), .NREG(NREG), .DEPTH(DEPTH), .CW(CW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_frame(in_frame),
  .commit_ev(commit_ev), .commit_sel(commit_sel),
  .wr_ev(wr_ev), .wr_sel(wr_sel), .done_set_i(done_set_i),
  .fill_o(fill_o), .done_o(done_o), .reg_o(reg_o)
);

// File: tb/serial_write_rx_bench.sv
module serial_write_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, strobe = 1'b0, sdata = 1'b0;
  logic [3:0]  done_set = '0;
  logic [1:0]  rd_sel = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] fill, txlen;
  logic [3:0]  tog, done;
  logic [31:0] regs;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_write_rx u_serial_write_rx (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .strobe_i(strobe), .sdata_i(sdata),
    .done_set_i(done_set), .rd_sel_i(rd_sel), .rd_idx_i(rd_idx),
    .fill_o(fill), .txlen_o(txlen), .tog_o(tog), .done_o(done),
    .reg_o(regs), .rd_data_o(rd_data)
  );

  // {control byte, data byte count, seed}
  localparam logic [19:0] VEC [5] = '{
    {8'h03, 4'd3,  8'h11},
    {8'h35, 4'd5,  8'hA0},
    {8'h48, 4'd8,  8'h3C},
    {8'h74, 4'd11, 8'h05},
    {8'h01, 4'd1,  8'hFE}
  };

  function automatic logic [7:0] dbyte(logic [7:0] seed, int i);
    return 8'(int'(seed) + i * 37);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdata = b;
    wait_clk(4);
    sck = 1'b1;
    wait_clk(4);
    sck = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  // ctl_bits: number of control-byte bits sent (8 = whole byte)
  task automatic send_frame(logic [7:0] ctl, int ctl_bits, int n, logic [7:0] seed, int tail_bits);
    strobe = 1'b1;
    wait_clk(6);
    for (int i = 0; i < ctl_bits; i++) send_bit(ctl[i]);
    for (int k = 0; k < n; k++) send_byte(dbyte(seed, k));
    for (int t = 0; t < tail_bits; t++) send_bit(t[0] == 1'b0);
    wait_clk(4);
    sdata = 1'b0;
    wait_clk(3);
    strobe = 1'b0;
    wait_clk(10);
  endtask

  task automatic rearm();
    done_set = 4'hF;
    wait_clk(1);
    done_set = 4'h0;
    wait_clk(1);
  endtask

  function automatic int fill_of(int f);
    return int'(fill[f*4 +: 4]);
  endfunction

  function automatic int len_of(int f);
    return int'(txlen[f*4 +: 4]);
  endfunction

  task automatic peek(int f, int idx, output logic [7:0] val);
    rd_sel = 2'(f);
    rd_idx = 3'(idx);
    #1;
    val = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ctl, seed, v;
    int n, tgt, exp_fill, first;
    logic [15:0] fill_before;

    wait_clk(5);
    // R1 reset state
    chk("R1 fill", int'(fill), 0);
    chk("R1 done", int'(done), 4'hF);
    chk("R1 regs", int'(regs), 0);
    chk("R1 txlen", int'(txlen), 0);
    rst_n = 1'b1;
    wait_clk(3);

    // R2 R3 R4 R5 R6: table-driven FIFO frames
    for (int vi = 0; vi < 5; vi++) begin
      ctl  = VEC[vi][19:12];
      n    = int'(VEC[vi][11:8]);
      seed = VEC[vi][7:0];
      tgt  = int'(ctl[7:5]);
      rearm();
      chk("R11 done set", int'(done[tgt]), 1);
      send_frame(ctl, 8, n, seed, 0);
      exp_fill = (n > 8) ? 8 : n;
      first = n - exp_fill;
      chk("R4 fill", fill_of(tgt), exp_fill);
      chk("R6 done cleared", int'(done[tgt]), 0);
      chk("R6 txlen", len_of(tgt), int'(ctl[3:0]));
      chk("R3 toggle", int'(tog[tgt]), int'(ctl[4]));
      for (int k = 0; k < exp_fill; k++) begin
        peek(tgt, k, v);
        chk((n > 8) ? "R5 wrapped data" : "R2 data order", int'(v), int'(dbyte(seed, first + k)));
      end
    end

    // R7 register target: length/toggle ignored, fills and done untouched
    rearm();
    fill_before = fill;
    send_frame(8'hBF, 8, 2, 8'h12, 0);
    chk("R7 register last byte", int'(regs[15:8]), int'(dbyte(8'h12, 1)));
    chk("R7 other register", int'(regs[7:0]), 0);
    chk("R7 fills", int'(fill), int'(fill_before));
    chk("R7 done", int'(done), 4'hF);

    // R8 zero length without the extra clock: no commit
    rearm();
    send_frame(8'h20, 8, 0, 8'h00, 0);
    chk("R8 no commit done", int'(done[1]), 1);
    chk("R8 no commit txlen", len_of(1), 5);
    chk("R4 fill emptied", fill_of(1), 0);

    // R8 zero length with exactly one extra clock: commit
    send_frame(8'h40, 8, 0, 8'h00, 1);
    chk("R8 commit done", int'(done[2]), 0);
    chk("R8 commit txlen", len_of(2), 0);
    chk("R8 commit fill", fill_of(2), 0);

    // R9 trailing partial byte discarded
    rearm();
    send_frame(8'h02, 8, 2, 8'h77, 5);
    chk("R9 partial fill", fill_of(0), 2);
    peek(0, 0, v);
    chk("R9 data0", int'(v), int'(dbyte(8'h77, 0)));
    peek(0, 1, v);
    chk("R9 data1", int'(v), int'(dbyte(8'h77, 1)));
    chk("R9 txlen", len_of(0), 2);

    // R9 frame cut inside the control byte
    rearm();
    fill_before = fill;
    send_frame(8'h03, 5, 0, 8'h00, 0);
    chk("R9 cut control fill", int'(fill), int'(fill_before));
    chk("R9 cut control done", int'(done), 4'hF);

    // R10 clocks while strobe low
    fill_before = fill;
    for (int i = 0; i < 24; i++) send_bit(i[1]);
    wait_clk(8);
    chk("R10 fills", int'(fill), int'(fill_before));
    chk("R10 regs", int'(regs[15:8]), int'(dbyte(8'h12, 1)));
    peek(0, 0, v);
    chk("R10 data", int'(v), int'(dbyte(8'h77, 0)));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule